// File: doc/BRIEF.md
# Video Test Pattern Source

This block sits on a display output path just before the stream packer and can replace the live picture with a generated test image. Each pixel carries 12 bits per colour component. The image is either eight vertical colour bars of equal width or one solid colour that software programs. The bars can stand still, or they can rotate one bar position to the right once every N frames, with N from 1 to 255.

The block follows the hsync, vsync and data-enable signals of the incoming video, or it makes its own timing from programmable line and frame sizes. Software reaches it through a plain write port. It writes the two control words into a shadow copy and then writes a commit word. The shadow copy becomes live at the next rising vsync of the timing currently in use, so a frame is never built from two settings. When the block is disabled, the incoming pixels and syncs pass through unchanged.

Top module: `cbar_gen`

## Requirements
- R1: While reset is asserted, every output (vid_hs, vid_vs, vid_de, vid_r, vid_g, vid_b) is zero.
- R2: While the live enable bit is 0, every output equals the matching ext_* input one clock later.
- R3: A write to control word A (0x260) or B (0x264) changes nothing at the outputs until a write to the commit address (0x268) has been made and a rising vsync has then occurred on the timing currently in use. Only at that vsync do both words become live.
- R4: With internal timing (word A bit 9 = 1), a line lasts htotal clocks and a frame lasts htotal*vtotal clocks. Data-enable is high exactly for hactive clocks per line on the first vactive lines. vid_hs is high when the column ≥ hactive, and vid_vs is high when the line ≥ vactive. The line word (0x270) holds hactive in [11:0] and htotal in [23:12]. The frame word (0x274) holds vactive in [11:0] and vtotal in [23:12]. Both take effect without a commit. Reset values are 16/20 and 4/6.
- R5: In bar mode (word A bit 10 = 0), each active line is split into 8 bars of hactive/8 pixels. Bar b shows palette entry ((b − offset) mod 8) + 1. The palette, with 0x800 as half and 0xFFF as full intensity, is: 1 white (FFF,FFF,FFF), 2 red (FFF,000,000), 3 orange (FFF,800,000), 4 yellow (FFF,FFF,000), 5 green (000,FFF,000), 6 cyan (000,800,800), 7 blue (000,000,FFF), 8 purple (800,000,800).
- R6: In solid mode (word A bit 10 = 1), every active pixel is red = word A [23:12], green = word B [23:12] and blue = word B [11:0].
- R7: Word A [8:1] is the rate. With rate 0, the offset is cleared at each frame start and the image is static. With rate N > 0, the offset grows by one, modulo 8, once every N frame starts.
- R8: When the block is enabled with external timing (word A bit 9 = 0), vid_hs, vid_vs and vid_de equal ext_hs, ext_vs and ext_de one clock later. Bar counting restarts at the first pixel of every ext_de run.
- R9: When the block is enabled, vid_r, vid_g and vid_b are zero in every clock where vid_de is 0.
- R10: The enable bit is word A bit 0. The rate, timing-source and mode bits are as given in R7, R8 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 24 | Register write data |
| ext_hs | input | 1 | External horizontal sync |
| ext_vs | input | 1 | External vertical sync |
| ext_de | input | 1 | External data enable |
| ext_r | input | 12 | External red |
| ext_g | input | 12 | External green |
| ext_b | input | 12 | External blue |
| vid_hs | output | 1 | Output horizontal sync |
| vid_vs | output | 1 | Output vertical sync |
| vid_de | output | 1 | Output data enable |
| vid_r | output | 12 | Output red |
| vid_g | output | 12 | Output green |
| vid_b | output | 12 | Output blue |

## Verification
The bars are checked pixel by pixel at two bar widths (2 and 3 pixels), so a wrong bar boundary or a wrong palette entry shows up at a specific column. Rotation is tried at rates 1, 2 and 0. The offset of each frame is recovered from the first pixel, which separates rotating every frame, rotating every second frame and standing still. Solid mode uses three different component values, which exposes swapped or misplaced fields. External timing is driven by hand with two separate enable runs, to show that bar counting restarts on each run. Shadowing is tested by holding pass-through values first after uncommitted writes and then after a commit with no vsync.

// File: rtl/cbar_pkg.sv
package cbar_pkg;

  localparam int CW    = 12;
  localparam int NBARS = 8;

  localparam logic [11:0] ADR_CTRL_A = 12'h260;
  localparam logic [11:0] ADR_CTRL_B = 12'h264;
  localparam logic [11:0] ADR_COMMIT = 12'h268;
  localparam logic [11:0] ADR_LINE   = 12'h270;
  localparam logic [11:0] ADR_FRAME  = 12'h274;

  typedef struct packed {
    logic [CW-1:0] r;
    logic [CW-1:0] g;
    logic [CW-1:0] b;
  } rgb_t;

  typedef struct packed {
    logic          en;
    logic          self_tm;
    logic          solid;
    logic [7:0]    rate;
    rgb_t          fill;
  } cbar_cfg_t;

  // Fixed colour table; 0 and 9 and above give black.
  function automatic rgb_t palette(input logic [3:0] idx);
    logic [CW-1:0] f;
    logic [CW-1:0] h;
    rgb_t c;
    f = '1;
    h = CW'(1) << (CW - 1);
    case (idx)
      4'd1:    c = '{r: f,  g: f,  b: f};
      4'd2:    c = '{r: f,  g: '0, b: '0};
      4'd3:    c = '{r: f,  g: h,  b: '0};
      4'd4:    c = '{r: f,  g: f,  b: '0};
      4'd5:    c = '{r: '0, g: f,  b: '0};
      4'd6:    c = '{r: '0, g: h,  b: h};
      4'd7:    c = '{r: '0, g: '0, b: f};
      4'd8:    c = '{r: h,  g: '0, b: h};
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/cbar_regs.sv
module cbar_regs
  import cbar_pkg::*;
#(
  parameter int AW       = 12,
  parameter int DW       = 24,
  parameter int TW       = 12,
  parameter int HACT_RST = 16,
  parameter int HTOT_RST = 20,
  parameter int VACT_RST = 4,
  parameter int VTOT_RST = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          frame_start,
  output cbar_cfg_t     cfg,
  output logic [TW-1:0] hact,
  output logic [TW-1:0] htot,
  output logic [TW-1:0] vact,
  output logic [TW-1:0] vtot
);

  localparam int AKW = 23;  // word A kept bits: [23:12] and [10:0]

  logic [AKW-1:0] sha_q, sha_d, acta_q, acta_d;
  logic [DW-1:0]  shb_q, shb_d, actb_q, actb_d;
  logic           pend_q, pend_d;
  logic [TW-1:0]  hact_q, hact_d, htot_q, htot_d;
  logic [TW-1:0]  vact_q, vact_d, vtot_q, vtot_d;
  logic           wr_a, wr_b, wr_c, wr_l, wr_f, apply;

  always_comb begin
    wr_a   = we && (addr == AW'(ADR_CTRL_A));
    wr_b   = we && (addr == AW'(ADR_CTRL_B));
    wr_c   = we && (addr == AW'(ADR_COMMIT));
    wr_l   = we && (addr == AW'(ADR_LINE));
    wr_f   = we && (addr == AW'(ADR_FRAME));
    apply  = frame_start && pend_q;
    sha_d  = wr_a ? {wdata[23:12], wdata[10:0]} : sha_q;
    shb_d  = wr_b ? wdata : shb_q;
    acta_d = apply ? sha_q : acta_q;
    actb_d = apply ? shb_q : actb_q;
    if (wr_c)       pend_d = 1'b1;
    else if (apply) pend_d = 1'b0;
    else            pend_d = pend_q;
    hact_d = wr_l ? wdata[TW-1:0]    : hact_q;
    htot_d = wr_l ? wdata[2*TW-1:TW] : htot_q;
    vact_d = wr_f ? wdata[TW-1:0]    : vact_q;
    vtot_d = wr_f ? wdata[2*TW-1:TW] : vtot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sha_q  <= '0;
      shb_q  <= '0;
      acta_q <= '0;
      actb_q <= '0;
      pend_q <= 1'b0;
      hact_q <= TW'(HACT_RST);
      htot_q <= TW'(HTOT_RST);
      vact_q <= TW'(VACT_RST);
      vtot_q <= TW'(VTOT_RST);
    end else begin
      sha_q  <= sha_d;
      shb_q  <= shb_d;
      acta_q <= acta_d;
      actb_q <= actb_d;
      pend_q <= pend_d;
      hact_q <= hact_d;
      htot_q <= htot_d;
      vact_q <= vact_d;
      vtot_q <= vtot_d;
    end
  end

  always_comb begin
    cfg.en      = acta_q[0];
    cfg.rate    = acta_q[8:1];
    cfg.self_tm = acta_q[9];
    cfg.solid   = acta_q[10];
    cfg.fill.r  = acta_q[22:11];
    cfg.fill.g  = actb_q[23:12];
    cfg.fill.b  = actb_q[11:0];
  end

  assign hact = hact_q;
  assign htot = htot_q;
  assign vact = vact_q;
  assign vtot = vtot_q;

  // R3: live settings move only on the clock after a frame start
  assert_live_at_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(acta_q) || !$stable(actb_q)) |-> $past(frame_start));

endmodule

// File: rtl/cbar_timing.sv
module cbar_timing #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] hact,
  input  logic [TW-1:0] htot,
  input  logic [TW-1:0] vact,
  input  logic [TW-1:0] vtot,
  output logic          hs,
  output logic          vs,
  output logic          de
);

  logic [TW-1:0] hcnt_q, hcnt_d, vcnt_q, vcnt_d;
  logic          line_end;

  always_comb begin
    line_end = (hcnt_q >= htot - 1'b1);
    hcnt_d   = line_end ? '0 : hcnt_q + 1'b1;
    if (!line_end)                   vcnt_d = vcnt_q;
    else if (vcnt_q >= vtot - 1'b1)  vcnt_d = '0;
    else                             vcnt_d = vcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      vcnt_q <= '0;
    end else begin
      hcnt_q <= hcnt_d;
      vcnt_q <= vcnt_d;
    end
  end

  assign de = (hcnt_q < hact) && (vcnt_q < vact);
  assign hs = (hcnt_q >= hact);
  assign vs = (vcnt_q >= vact);

  // R4: the line counter only steps at the start of a line
  assert_line_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vcnt_q) |-> (hcnt_q == '0));

endmodule

// File: rtl/cbar_pattern.sv
module cbar_pattern
  import cbar_pkg::*;
#(
  parameter int TW   = 12,
  localparam int BWW = TW - 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           de,
  input  logic           frame_start,
  input  logic [BWW-1:0] bar_w,
  input  logic [7:0]     rate,
  input  logic           solid,
  input  rgb_t           fill,
  output rgb_t           pix
);

  localparam int BIW = $clog2(NBARS);

  logic [BWW-1:0] bpix_q, bpix_d;
  logic [BIW-1:0] bidx_q, bidx_d, off_q, off_d, cidx;
  logic [7:0]     fcnt_q, fcnt_d;

  always_comb begin
    if (!de) begin
      bpix_d = '0;
      bidx_d = '0;
    end else if (bpix_q >= bar_w - 1'b1) begin
      bpix_d = '0;
      bidx_d = bidx_q + 1'b1;
    end else begin
      bpix_d = bpix_q + 1'b1;
      bidx_d = bidx_q;
    end
  end

  always_comb begin
    fcnt_d = fcnt_q;
    off_d  = off_q;
    if (frame_start) begin
      if (rate == 8'd0) begin
        fcnt_d = '0;
        off_d  = '0;
      end else if (fcnt_q >= rate - 8'd1) begin
        fcnt_d = '0;
        off_d  = off_q + 1'b1;
      end else begin
        fcnt_d = fcnt_q + 8'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bpix_q <= '0;
      bidx_q <= '0;
      fcnt_q <= '0;
      off_q  <= '0;
    end else begin
      bpix_q <= bpix_d;
      bidx_q <= bidx_d;
      fcnt_q <= fcnt_d;
      off_q  <= off_d;
    end
  end

  always_comb begin
    cidx = bidx_q - off_q;
    pix  = solid ? fill : palette(4'({1'b0, cidx}) + 4'd1);
  end

  // R7: rotation offset moves only after a frame start
  assert_offset_at_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(off_q) |-> $past(frame_start));

  // R5: bars advance one position at a time within a run
  assert_bar_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(de) |-> (bidx_q == $past(bidx_q)) || (bidx_q == $past(bidx_q) + 1'b1));

endmodule

// File: rtl/cbar_gen.sv
module cbar_gen
  import cbar_pkg::*;
#(
  parameter int AW       = 12,
  parameter int DW       = 24,
  parameter int TW       = 12,
  parameter int HACT_RST = 16,
  parameter int HTOT_RST = 20,
  parameter int VACT_RST = 4,
  parameter int VTOT_RST = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          ext_hs,
  input  logic          ext_vs,
  input  logic          ext_de,
  input  logic [11:0]   ext_r,
  input  logic [11:0]   ext_g,
  input  logic [11:0]   ext_b,
  output logic          vid_hs,
  output logic          vid_vs,
  output logic          vid_de,
  output logic [11:0]   vid_r,
  output logic [11:0]   vid_g,
  output logic [11:0]   vid_b
);

  cbar_cfg_t     cfg;
  logic [TW-1:0] hact, htot, vact, vtot;
  logic          tg_hs, tg_vs, tg_de;
  logic          sel_hs, sel_vs, sel_de;
  logic          vs_q, frame_start;
  rgb_t          pix, ext_pix;
  logic          hs_q, hs_d, vso_q, vso_d, de_q, de_d;
  rgb_t          rgb_q, rgb_d;

  cbar_regs #(
    .AW(AW), .DW(DW), .TW(TW),
    .HACT_RST(HACT_RST), .HTOT_RST(HTOT_RST),
    .VACT_RST(VACT_RST), .VTOT_RST(VTOT_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .frame_start(frame_start), .cfg(cfg),
    .hact(hact), .htot(htot), .vact(vact), .vtot(vtot)
  );

  cbar_timing #(.TW(TW)) u_timing (
    .clk(clk), .rst_n(rst_n),
    .hact(hact), .htot(htot), .vact(vact), .vtot(vtot),
    .hs(tg_hs), .vs(tg_vs), .de(tg_de)
  );

  always_comb begin
    sel_hs      = cfg.self_tm ? tg_hs : ext_hs;
    sel_vs      = cfg.self_tm ? tg_vs : ext_vs;
    sel_de      = cfg.self_tm ? tg_de : ext_de;
    frame_start = sel_vs && !vs_q;
    ext_pix     = '{r: ext_r, g: ext_g, b: ext_b};
  end

  cbar_pattern #(.TW(TW)) u_pattern (
    .clk(clk), .rst_n(rst_n), .de(sel_de), .frame_start(frame_start),
    .bar_w(hact[TW-1:3]), .rate(cfg.rate), .solid(cfg.solid),
    .fill(cfg.fill), .pix(pix)
  );

  always_comb begin
    if (cfg.en) begin
      hs_d  = sel_hs;
      vso_d = sel_vs;
      de_d  = sel_de;
      rgb_d = sel_de ? pix : '0;
    end else begin
      hs_d  = ext_hs;
      vso_d = ext_vs;
      de_d  = ext_de;
      rgb_d = ext_pix;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q  <= 1'b0;
      hs_q  <= 1'b0;
      vso_q <= 1'b0;
      de_q  <= 1'b0;
      rgb_q <= '0;
    end else begin
      vs_q  <= sel_vs;
      hs_q  <= hs_d;
      vso_q <= vso_d;
      de_q  <= de_d;
      rgb_q <= rgb_d;
    end
  end

  assign vid_hs = hs_q;
  assign vid_vs = vso_q;
  assign vid_de = de_q;
  assign vid_r  = rgb_q.r;
  assign vid_g  = rgb_q.g;
  assign vid_b  = rgb_q.b;

  // R2: disabled means a one-clock copy of the external video
  assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(cfg.en) |->
      (vid_de == $past(ext_de)) && (vid_hs == $past(ext_hs)) &&
      (vid_vs == $past(ext_vs)) && ({vid_r, vid_g, vid_b} == $past({ext_r, ext_g, ext_b})));

  // R9: generated blanking is black
  assert_blank_black_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(cfg.en) && !vid_de |-> ({vid_r, vid_g, vid_b} == '0));

endmodule

// File: tb/cbar_gen_tb.sv
module cbar_gen_tb;

  localparam int CLK_P = 10;

  logic        clk, rst_n, reg_we;
  logic [11:0] reg_addr;
  logic [23:0] reg_wdata;
  logic        ext_hs, ext_vs, ext_de;
  logic [11:0] ext_r, ext_g, ext_b;
  logic        vid_hs, vid_vs, vid_de;
  logic [11:0] vid_r, vid_g, vid_b;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  cbar_gen u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ext_hs(ext_hs), .ext_vs(ext_vs), .ext_de(ext_de),
    .ext_r(ext_r), .ext_g(ext_g), .ext_b(ext_b),
    .vid_hs(vid_hs), .vid_vs(vid_vs), .vid_de(vid_de),
    .vid_r(vid_r), .vid_g(vid_g), .vid_b(vid_b)
  );

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [35:0] pal(input int c);
    case (c)
      1: return {12'hFFF, 12'hFFF, 12'hFFF};
      2: return {12'hFFF, 12'h000, 12'h000};
      3: return {12'hFFF, 12'h800, 12'h000};
      4: return {12'hFFF, 12'hFFF, 12'h000};
      5: return {12'h000, 12'hFFF, 12'h000};
      6: return {12'h000, 12'h800, 12'h800};
      7: return {12'h000, 12'h000, 12'hFFF};
      8: return {12'h800, 12'h000, 12'h800};
      default: return 36'h0;
    endcase
  endfunction

  function automatic logic [35:0] bar_exp(input int i, input int bw, input int off);
    return pal((((i / bw) - off) % 8 + 8) % 8 + 1);
  endfunction

  function automatic logic [35:0] pix_now();
    return {vid_r, vid_g, vid_b};
  endfunction

  task automatic wr(input logic [11:0] a, input logic [23:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic drive_ext(input logic hs, input logic vs, input logic de, input logic [35:0] c);
    ext_hs = hs; ext_vs = vs; ext_de = de;
    {ext_r, ext_g, ext_b} = c;
  endtask

  task automatic commit_int();
    wr(12'h268, 24'h0);
    repeat (400) @(negedge clk);
  endtask

  task automatic wait_vs_rise();
    logic p;
    p = vid_vs;
    forever begin
      @(negedge clk);
      if (vid_vs && !p) break;
      p = vid_vs;
    end
  endtask

  task automatic wait_de_rise();
    logic p;
    p = vid_de;
    forever begin
      @(negedge clk);
      if (vid_de && !p) break;
      p = vid_de;
    end
  endtask

  // starts on pixel 0 of a line
  task automatic check_line(input string req, input int hact, input int bw, input int off);
    for (int i = 0; i < hact; i++) begin
      chk(req, $sformatf("bar pixel %0d", i), pix_now(), bar_exp(i, bw, off));
      @(negedge clk);
    end
  endtask

  task automatic measure_frame(input int htot, input int hact, input int vtot, input int vact);
    int n, nde, run, maxrun, bad;
    logic pvs;
    n = 0; nde = 0; run = 0; maxrun = 0; bad = 0;
    wait_vs_rise();
    pvs = 1'b1;
    forever begin
      @(negedge clk);
      n++;
      if (vid_de) begin
        nde++; run++;
        if (run > maxrun) maxrun = run;
      end else begin
        run = 0;
        if (pix_now() != 36'h0) bad++;
      end
      if (vid_vs && !pvs) break;
      pvs = vid_vs;
    end
    chk("R4", "frame length", 36'(n), 36'(htot * vtot));
    chk("R4", "active pixels per frame", 36'(nde), 36'(hact * vact));
    chk("R4", "active run length", 36'(maxrun), 36'(hact));
    chk("R9", "non-black blanking pixels", 36'(bad), 36'h0);
  endtask

  task automatic frame_offset(input int hact, input int bw, output int off);
    int c;
    wait_vs_rise();
    wait_de_rise();
    c = -1;
    for (int k = 1; k <= 8; k++) if (pal(k) == pix_now()) c = k;
    chk("R5", "first pixel is a palette colour", 36'(c != -1), 36'h1);
    off = (c < 1) ? 0 : (9 - c) % 8;
    check_line("R5", hact, bw, off);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    drive_ext(1'b0, 1'b0, 1'b0, 36'h0);
    repeat (3) @(negedge clk);
    chk("R1", "syncs in reset", {33'h0, vid_hs, vid_vs, vid_de}, 36'h0);
    chk("R1", "pixel in reset", pix_now(), 36'h0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_bypass();
    for (int k = 0; k < 6; k++) begin
      logic [35:0] c;
      c = {12'(k * 273 + 5), 12'(4095 - k * 7), 12'(k * 600)};
      drive_ext(k[0], k[1], k[2], c);
      @(negedge clk);
      chk("R2", "bypass syncs", {33'h0, vid_hs, vid_vs, vid_de}, {33'h0, k[0], k[1], k[2]});
      chk("R2", "bypass pixel", pix_now(), c);
    end
    drive_ext(1'b0, 1'b0, 1'b0, 36'h0);
    @(negedge clk);
  endtask

  task automatic t_shadow();
    wr(12'h260, 24'h000201);  // R10: enable bit 0, internal timing bit 9
    wr(12'h264, 24'h0);
    drive_ext(1'b0, 1'b0, 1'b1, 36'hABC_DEF_123);
    repeat (150) @(negedge clk);
    chk("R3", "uncommitted write leaves bypass", {vid_de, pix_now()}, {1'b1, 36'hABC_DEF_123});
    wr(12'h268, 24'h0);
    repeat (20) @(negedge clk);
    chk("R3", "commit without vsync leaves bypass", {vid_de, pix_now()}, {1'b1, 36'hABC_DEF_123});
    drive_ext(1'b0, 1'b1, 1'b1, 36'hABC_DEF_123);
    @(negedge clk);
    drive_ext(1'b0, 1'b0, 1'b0, 36'h0);
    measure_frame(20, 16, 6, 4);
  endtask

  task automatic t_static_bars();
    int off;
    frame_offset(16, 2, off);
    chk("R7", "reset rate gives zero offset", 36'(off), 36'h0);
  endtask

  task automatic t_rate(input int rate);
    int o[5];
    wr(12'h260, 24'(1 | (rate << 1) | (1 << 9)));
    commit_int();
    for (int f = 0; f < 5; f++) frame_offset(16, 2, o[f]);
    for (int f = 0; f < 5; f++) begin
      if (rate == 0)
        chk("R7", "static offset", 36'(o[f]), 36'h0);
      else if (f + rate < 5)
        chk("R7", $sformatf("offset after %0d frames", rate), 36'((o[f + rate] - o[f] + 8) % 8), 36'h1);
      if (rate > 1 && f < 4)
        chk("R7", "per-frame step at most one", 36'((o[f + 1] - o[f] + 8) % 8 <= 1), 36'h1);
    end
  endtask

  task automatic t_solid();
    logic [35:0] c;
    c = {12'h123, 12'h456, 12'h789};
    wr(12'h260, 24'h123601);  // R6: bit 10 solid, red in [23:12]
    wr(12'h264, 24'h456789);
    commit_int();
    wait_de_rise();
    for (int i = 0; i < 16; i++) begin
      chk("R6", $sformatf("solid pixel %0d", i), pix_now(), c);
      @(negedge clk);
    end
    measure_frame(20, 16, 6, 4);
  endtask

  task automatic t_prog_timing();
    int off;
    wr(12'h260, 24'h000201);
    commit_int();
    wr(12'h270, 24'h01E018);  // htotal 30, hactive 24
    wr(12'h274, 24'h004002);  // vtotal 4, vactive 2
    repeat (300) @(negedge clk);
    measure_frame(30, 24, 4, 2);
    frame_offset(24, 3, off);
    chk("R7", "zero offset with rate 0", 36'(off), 36'h0);
  endtask

  task automatic t_ext_timing();
    wr(12'h260, 24'h000001);  // enabled, external timing, bars
    commit_int();
    drive_ext(1'b0, 1'b1, 1'b0, 36'h0);
    @(negedge clk);
    drive_ext(1'b0, 1'b0, 1'b0, 36'h0);
    repeat (3) @(negedge clk);
    for (int ln = 0; ln < 2; ln++) begin
      drive_ext(1'b0, 1'b0, 1'b1, 36'hFFF_FFF_FFF);
      for (int i = 0; i < 24; i++) begin
        @(negedge clk);
        chk("R8", $sformatf("ext line %0d de at %0d", ln, i), {35'h0, vid_de}, 36'h1);
        chk("R8", $sformatf("ext line %0d pixel %0d", ln, i), pix_now(), bar_exp(i, 3, 0));
        if (i == 23) drive_ext(1'b1, 1'b0, 1'b0, 36'hFFF_FFF_FFF);
      end
      @(negedge clk);
      chk("R8", "ext hs/de follow", {34'h0, vid_hs, vid_de}, {34'h0, 1'b1, 1'b0});
      chk("R9", "ext blanking black", pix_now(), 36'h0);
      drive_ext(1'b0, 1'b0, 1'b0, 36'h0);
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_shadow();
    t_static_bars();
    t_rate(1);
    t_rate(2);
    t_rate(0);
    t_solid();
    t_prog_timing();
    t_ext_timing();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule